// File: doc/BRIEF.md
# Channel Interrupt Vector Generator

This block sits between a bank of timer channels and the interrupt logic of the system. Each channel holds its request line high until the block clears it. When any channel requests and the programmed level is non-zero, the block presents that level on its request output. A level of zero turns all channel interrupts off. A level of seven is the nonmaskable level. One level setting applies to every channel.

The interrupt controller runs an acknowledge cycle with a one-cycle strobe. The strobe carries the level being acknowledged and the arbitration ID of the module that has won. Each requesting module holds a unique non-zero arbitration ID. The block answers only when both the level and the ID match its own settings. Its answer is a one-cycle vector byte and a clear pulse to the serviced channel. The vector's high nibble is a programmed base and its low nibble is the channel index. When several channels request at once, the lowest-numbered channel is answered first.

Top module: `chan_irq_vec`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, irq_lvl_o, vec_vld_o, vec_o and clr_o are all zero.
- R2: One clock edge after any bit of req_i is high and cfg_lvl_i is non-zero, irq_lvl_o equals cfg_lvl_i. One clock edge after req_i is all zero, irq_lvl_o is 0.
- R3: When cfg_lvl_i is 0, irq_lvl_o stays 0 and no acknowledge is answered, whatever req_i holds.
- R4: A cfg_lvl_i of 7 (nonmaskable) is presented as 7 on irq_lvl_o. An acknowledge at level 7 is answered in the same way as any other level.
- R5: An acknowledge is answered only when ack_i is high, ack_lvl_i equals cfg_lvl_i and ack_id_i equals cfg_id_i. The answer is vec_vld_o high for exactly the one cycle after the strobe edge. A mismatch in level or ID gives no answer.
- R6: When vec_vld_o is high, vec_o[7:4] is cfg_base_i and vec_o[3:0] is the serviced channel index, both as sampled at the strobe edge.
- R7: When several bits of req_i are high at the strobe, the serviced channel is the lowest-numbered set bit.
- R8: clr_o is one-hot with bit n set for the serviced channel n in the cycle vec_vld_o is high. clr_o is all zero in every other cycle.
- R9: When cfg_id_i is 0, no acknowledge is ever answered, even one with ack_id_i of 0. irq_lvl_o still follows R2.
- R10: A matching acknowledge while req_i is all zero gives no answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Channel request lines, held until cleared |
| cfg_lvl_i | input | 3 | Request level for all channels; 0 disables, 7 nonmaskable |
| cfg_base_i | input | 4 | High nibble of every channel vector |
| cfg_id_i | input | 4 | Module arbitration ID; 0 means never answer |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| ack_lvl_i | input | 3 | Level being acknowledged |
| ack_id_i | input | 4 | Arbitration ID being serviced |
| irq_lvl_o | output | 3 | Requested level, 0 when idle |
| vec_vld_o | output | 1 | Vector valid, one cycle |
| vec_o | output | 8 | Vector number {base, channel} |
| clr_o | output | 16 | One-hot clear pulse for the serviced channel |

## Verification
The hardest case to reach is a drain of several channels that are pending together, because each answer must pick the next-lowest bit. The stimulus reaches it with pseudo-random 16-bit request patterns held on req_i. The bench then issues matching acknowledges one after another and drops each cleared bit before the next strobe. It checks that the channel order is ascending and that every channel is served exactly once. A full sweep over all channels at every level from 1 to 7 covers the vector arithmetic. Separate phases with a zero level, a zero ID and wrong level or ID values check that no answer is given.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int unsigned DEF_NUM_CH = 16;
  localparam int unsigned DEF_LVL_W  = 3;
  localparam int unsigned DEF_ID_W   = 4;
  localparam int unsigned DEF_BASE_W = 4;
endpackage

// File: rtl/chan_pick.sv
module chan_pick #(
  parameter int unsigned NUM_CH = chan_irq_pkg::DEF_NUM_CH,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o,
  output logic [NUM_CH-1:0] onehot_o
);
  // scan high to low so the lowest set bit is the final assignment
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = CH_W'(i);
      end
    end
  end

  assign onehot_o = req_i & (~req_i + NUM_CH'(1));
endmodule

// File: rtl/irq_level.sv
module irq_level #(
  parameter int unsigned LVL_W = chan_irq_pkg::DEF_LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [LVL_W-1:0] cfg_lvl_i,
  output logic [LVL_W-1:0] irq_lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_lvl_o <= '0;
    else         irq_lvl_o <= any_i ? cfg_lvl_i : '0;
  end
endmodule

// File: rtl/ack_resp.sv
module ack_resp #(
  parameter int unsigned NUM_CH = chan_irq_pkg::DEF_NUM_CH,
  parameter int unsigned LVL_W  = chan_irq_pkg::DEF_LVL_W,
  parameter int unsigned ID_W   = chan_irq_pkg::DEF_ID_W,
  parameter int unsigned BASE_W = chan_irq_pkg::DEF_BASE_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned VEC_W = BASE_W + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ack_lvl_i,
  input  logic [ID_W-1:0]   ack_id_i,
  input  logic [LVL_W-1:0]  cfg_lvl_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic              any_i,
  input  logic [CH_W-1:0]   idx_i,
  input  logic [NUM_CH-1:0] onehot_i,
  output logic              vec_vld_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [NUM_CH-1:0] clr_o
);
  logic lvl_hit, id_hit, hit;

  assign lvl_hit = (cfg_lvl_i != '0) && (ack_lvl_i == cfg_lvl_i);
  assign id_hit  = (cfg_id_i != '0) && (ack_id_i == cfg_id_i);
  assign hit     = ack_i && any_i && lvl_hit && id_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_vld_o <= 1'b0;
      vec_o     <= '0;
      clr_o     <= '0;
    end else begin
      vec_vld_o <= hit;
      vec_o     <= hit ? {cfg_base_i, idx_i} : '0;
      clr_o     <= hit ? onehot_i : '0;
    end
  end
endmodule

// File: rtl/chan_irq_vec.sv
module chan_irq_vec #(
  parameter int unsigned NUM_CH = chan_irq_pkg::DEF_NUM_CH,
  parameter int unsigned LVL_W  = chan_irq_pkg::DEF_LVL_W,
  parameter int unsigned ID_W   = chan_irq_pkg::DEF_ID_W,
  parameter int unsigned BASE_W = chan_irq_pkg::DEF_BASE_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned VEC_W = BASE_W + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [LVL_W-1:0]  cfg_lvl_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ack_lvl_i,
  input  logic [ID_W-1:0]   ack_id_i,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic              vec_vld_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [NUM_CH-1:0] clr_o
);
  logic              any;
  logic [CH_W-1:0]   idx;
  logic [NUM_CH-1:0] onehot;

  chan_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req_i   (req_i),
    .any_o   (any),
    .idx_o   (idx),
    .onehot_o(onehot)
  );

  irq_level #(.LVL_W(LVL_W)) u_lvl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .any_i    (any),
    .cfg_lvl_i(cfg_lvl_i),
    .irq_lvl_o(irq_lvl_o)
  );

  ack_resp #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .ID_W(ID_W), .BASE_W(BASE_W)
  ) u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_i),
    .ack_lvl_i (ack_lvl_i),
    .ack_id_i  (ack_id_i),
    .cfg_lvl_i (cfg_lvl_i),
    .cfg_id_i  (cfg_id_i),
    .cfg_base_i(cfg_base_i),
    .any_i     (any),
    .idx_i     (idx),
    .onehot_i  (onehot),
    .vec_vld_o (vec_vld_o),
    .vec_o     (vec_o),
    .clr_o     (clr_o)
  );
endmodule

// File: rtl/chan_irq_vec_chk.sv
module chan_irq_vec_chk #(
  parameter int unsigned NUM_CH = chan_irq_pkg::DEF_NUM_CH,
  parameter int unsigned LVL_W  = chan_irq_pkg::DEF_LVL_W,
  parameter int unsigned ID_W   = chan_irq_pkg::DEF_ID_W,
  parameter int unsigned BASE_W = chan_irq_pkg::DEF_BASE_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned VEC_W = BASE_W + CH_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] req_i,
  input logic [LVL_W-1:0]  cfg_lvl_i,
  input logic [BASE_W-1:0] cfg_base_i,
  input logic [ID_W-1:0]   cfg_id_i,
  input logic              ack_i,
  input logic [LVL_W-1:0]  ack_lvl_i,
  input logic [ID_W-1:0]   ack_id_i,
  input logic [LVL_W-1:0]  irq_lvl_o,
  input logic              vec_vld_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [NUM_CH-1:0] clr_o
);
  logic [NUM_CH-1:0] served_bit, below_mask;
  assign served_bit = NUM_CH'(1) << vec_o[CH_W-1:0];
  assign below_mask = served_bit - NUM_CH'(1);

  a_r8_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  a_r8_clr_only_with_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_vld_o |-> clr_o == '0);
  a_r6_vec_matches_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> clr_o == served_bit);
  a_r6_vec_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> vec_o[VEC_W-1:CH_W] == $past(cfg_base_i));
  a_r5_vld_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(ack_i && ack_lvl_i == cfg_lvl_i && ack_id_i == cfg_id_i));
  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |=> !vec_vld_o || $past(ack_i));
  a_r7_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> ($past(req_i) & (below_mask | served_bit)) == served_bit);
  a_r9_zero_id_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_id_i) == '0 |-> !vec_vld_o);
  a_r3_zero_lvl_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_lvl_i) == '0 |-> irq_lvl_o == '0 && !vec_vld_o);
  a_r10_no_req_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i) == '0 |-> !vec_vld_o && irq_lvl_o == '0);
endmodule

bind chan_irq_vec chan_irq_vec_chk #(
  .NUM_CH(NUM_CH), .LVL_W(LVL_W), .ID_W(ID_W), .BASE_W(BASE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .cfg_lvl_i(cfg_lvl_i),
  .cfg_base_i(cfg_base_i), .cfg_id_i(cfg_id_i), .ack_i(ack_i),
  .ack_lvl_i(ack_lvl_i), .ack_id_i(ack_id_i), .irq_lvl_o(irq_lvl_o),
  .vec_vld_o(vec_vld_o), .vec_o(vec_o), .clr_o(clr_o)
);

// File: tb/tb_chan_irq_vec.sv
`timescale 1ns/1ps
module tb_chan_irq_vec;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic [2:0]  cfg_lvl_i = '0;
  logic [3:0]  cfg_base_i = '0;
  logic [3:0]  cfg_id_i = '0;
  logic        ack_i = 1'b0;
  logic [2:0]  ack_lvl_i = '0;
  logic [3:0]  ack_id_i = '0;
  logic [2:0]  irq_lvl_o;
  logic        vec_vld_o;
  logic [7:0]  vec_o;
  logic [15:0] clr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_irq_vec dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .cfg_lvl_i(cfg_lvl_i),
    .cfg_base_i(cfg_base_i), .cfg_id_i(cfg_id_i), .ack_i(ack_i),
    .ack_lvl_i(ack_lvl_i), .ack_id_i(ack_id_i), .irq_lvl_o(irq_lvl_o),
    .vec_vld_o(vec_vld_o), .vec_o(vec_o), .clr_o(clr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // strobe one cycle, then check the answer registered at that edge
  task automatic do_ack(input logic [2:0] lvl, input logic [3:0] id,
                        input bit exp_vld, input logic [7:0] exp_vec,
                        input logic [15:0] exp_clr, input string tag);
    @(negedge clk);
    ack_i = 1'b1; ack_lvl_i = lvl; ack_id_i = id;
    @(negedge clk);
    ack_i = 1'b0;
    check({tag, " vld"}, 32'(vec_vld_o), 32'(exp_vld));
    check({tag, " vec"}, 32'(vec_o), 32'(exp_vec));
    check({tag, " clr"}, 32'(clr_o), 32'(exp_clr));
  endtask

  function automatic int lowest(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) lowest = i;
    if (v == '0) lowest = -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] pend;
    cfg_id_i = 4'd9;
    repeat (3) @(negedge clk);
    // R1: reset values while held
    check("R1 lvl rst", 32'(irq_lvl_o), 0);
    check("R1 vld rst", 32'(vec_vld_o), 0);
    check("R1 clr rst", 32'(clr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 lvl post", 32'(irq_lvl_o), 0);
    check("R1 vec post", 32'(vec_o), 0);

    // R2 R4 R6 R8: every level and channel alone
    for (int l = 1; l < 8; l++) begin
      for (int c = 0; c < 16; c++) begin
        cfg_lvl_i = 3'(l);
        cfg_base_i = 4'((l * 3 + c) & 15);
        req_i = 16'(1) << c;
        @(negedge clk);
        check(l == 7 ? "R4 lvl nmi" : "R2 lvl", 32'(irq_lvl_o), 32'(l));
        do_ack(3'(l), 4'd9, 1'b1, {cfg_base_i, 4'(c)}, 16'(1) << c, "R6 R8 single");
        req_i = '0;
        @(negedge clk);
        check("R2 idle", 32'(irq_lvl_o), 0);
        check("R8 clr idle", 32'(clr_o), 0);
      end
    end

    // R7: drain random patterns lowest first
    lfsr = 16'hACE1;
    cfg_lvl_i = 3'd5; cfg_base_i = 4'hC;
    for (int p = 0; p < 60; p++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pend = lfsr;
      req_i = pend;
      while (pend != '0) begin
        int c;
        c = lowest(pend);
        do_ack(3'd5, 4'd9, 1'b1, {4'hC, 4'(c)}, 16'(1) << c, "R7 drain");
        pend = pend & ~(16'(1) << c);
        req_i = pend;
      end
    end

    // R5: level or id mismatch
    req_i = 16'h0104;
    for (int l = 0; l < 8; l++) begin
      if (l != 5) do_ack(3'(l), 4'd9, 1'b0, 8'h00, 16'h0, "R5 bad lvl");
    end
    for (int id = 0; id < 16; id++) begin
      if (id != 9) do_ack(3'd5, 4'(id), 1'b0, 8'h00, 16'h0, "R5 bad id");
    end
    check("R5 lvl held", 32'(irq_lvl_o), 5);

    // R10: matching strobe with nothing pending
    req_i = '0;
    @(negedge clk);
    do_ack(3'd5, 4'd9, 1'b0, 8'h00, 16'h0, "R10 empty");

    // R3: level 0 disables
    cfg_lvl_i = 3'd0;
    req_i = 16'hFFFF;
    @(negedge clk);
    check("R3 lvl0", 32'(irq_lvl_o), 0);
    do_ack(3'd0, 4'd9, 1'b0, 8'h00, 16'h0, "R3 ack0");

    // R9: id zero never answers
    cfg_lvl_i = 3'd3; cfg_id_i = 4'd0;
    @(negedge clk);
    check("R9 lvl still", 32'(irq_lvl_o), 3);
    do_ack(3'd3, 4'd0, 1'b0, 8'h00, 16'h0, "R9 id0");
    do_ack(3'd3, 4'd9, 1'b0, 8'h00, 16'h0, "R9 id0 other");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule